// File: doc/BRIEF.md
# Addressing-Mode Instruction Sequencer

This block generates the timing for a small 8-bit processor core. A machine cycle is four clocks long and is marked by a one-hot phase vector that rotates one position per clock. An instruction occupies one, two or three machine cycles. The count depends on a 2-bit addressing-mode code, which the opcode decoder provides while the first (fetch) cycle is under way.

The sequencer reports which machine cycle of the current instruction is running. It also raises single-clock strobes at four points: the opcode fetch, each operand fetch, the execute point and the end of the instruction. Decoding, arithmetic, memory and I/O sit outside the block.

Absolute-target branches use the direct code, because their operand access has the same length. Relative-target branches have a code of their own and take two machine cycles.

Top module: `instr_sequencer`

## Requirements
- R1: `phase_o` is always one-hot. After reset it holds 4'b0001 (P0) and rotates one position per clock, P0, P1, P2, P3, then back to P0.
- R2: `cycle_o` is 0 in the first machine cycle of every instruction. It changes only on the clock that takes the phase from P3 to P0.
- R3: Mode code 2'b00 (inherent) ends the instruction after one machine cycle (4 clocks).
- R4: Mode code 2'b01 (immediate) ends the instruction after two machine cycles (8 clocks).
- R5: Mode code 2'b10 (direct, also used for absolute branches) ends the instruction after three machine cycles (12 clocks). `cycle_o` never exceeds 2.
- R6: Mode code 2'b11 (relative branch) ends the instruction after two machine cycles (8 clocks).
- R7: `mode_i` must be valid during P2 and P3 of cycle 0. It is captured on the clock leaving P3 of cycle 0, and later changes have no effect on the instruction length or the strobes.
- R8: `done_o` is high only during P3 of the final machine cycle. On the following clock the phase is P0 and `cycle_o` is 0.
- R9: `fetch_o` is high only during P0 of cycle 0. `opfetch_o` is high only during P0 of cycles 1 and 2.
- R10: `exec_o` is high only during P2 of the final machine cycle.
- R11: A low `rst_n` immediately forces P0, cycle 0 and all strobes low. After `rst_n` rises, the first P0 stays in place for two rising edges, and the phase first advances on the third rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_i | input | 2 | Addressing-mode code from the decoder |
| phase_o | output | 4 | One-hot phase, bit 0 = P0 |
| cycle_o | output | 2 | Machine-cycle index within the instruction |
| fetch_o | output | 1 | Opcode fetch strobe |
| opfetch_o | output | 1 | Operand fetch strobe |
| exec_o | output | 1 | Execute strobe |
| done_o | output | 1 | End-of-instruction strobe |

## Verification
Phase and cycle index are registered and move on the rising edge after the state they follow from. The strobes are combinational from that state and from the live mode code during cycle 0, so a strobe is due in the same clock as the phase it names. The bench advances its own reference state on each rising edge, drives `mode_i` on the falling edge, and compares every output shortly after that. Instruction length is measured from DUT strobes in clocks, from `fetch_o` to `done_o` inclusive. The reset release gets a two-edge allowance that the bench counts explicitly.

// File: rtl/seq_pkg.sv
package seq_pkg;

  localparam int SEQ_NPHASE = 4;
  localparam int SEQ_CYC_W  = 2;
  localparam int SEQ_MODE_W = 2;

  typedef enum logic [SEQ_MODE_W-1:0] {
    MODE_INH = 2'b00,
    MODE_IMM = 2'b01,
    MODE_DIR = 2'b10,
    MODE_REL = 2'b11
  } seq_mode_e;

  // index of the final machine cycle for a given addressing mode
  function automatic logic [SEQ_CYC_W-1:0] last_cycle(seq_mode_e m);
    logic [SEQ_CYC_W-1:0] r;
    unique case (m)
      MODE_INH: r = SEQ_CYC_W'(0);
      MODE_IMM: r = SEQ_CYC_W'(1);
      MODE_DIR: r = SEQ_CYC_W'(2);
      default:  r = SEQ_CYC_W'(1);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/seq_reset_sync.sv
module seq_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_q_n = sync_q[STAGES-1];

endmodule

// File: rtl/seq_phase_ring.sv
module seq_phase_ring #(
  parameter int NPHASE = 4
) (
  input  logic              clk,
  input  logic              rst_q_n,
  output logic [NPHASE-1:0] phase_o,
  output logic              wrap_o
);

  logic [NPHASE-1:0] ph_q;
  logic [NPHASE-1:0] ph_d;

  always_comb begin
    ph_d = {ph_q[NPHASE-2:0], ph_q[NPHASE-1]};
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) ph_q <= NPHASE'(1);
    else          ph_q <= ph_d;
  end

  assign phase_o = ph_q;
  assign wrap_o  = ph_q[NPHASE-1];

endmodule

// File: rtl/seq_cycle_ctr.sv
module seq_cycle_ctr #(
  parameter int CYC_W = 2
) (
  input  logic             clk,
  input  logic             rst_q_n,
  input  logic             step_i,
  input  logic             clear_i,
  output logic [CYC_W-1:0] cycle_o
);

  logic [CYC_W-1:0] cyc_q;
  logic [CYC_W-1:0] cyc_d;
  logic             cyc_en;

  always_comb begin
    cyc_en = step_i;
    cyc_d  = clear_i ? '0 : cyc_q + CYC_W'(1);
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)    cyc_q <= '0;
    else if (cyc_en) cyc_q <= cyc_d;
  end

  assign cycle_o = cyc_q;

endmodule

// File: rtl/seq_mode_hold.sv
module seq_mode_hold #(
  parameter int CYC_W = 2
) (
  input  logic             clk,
  input  logic             rst_q_n,
  input  logic             capture_i,
  input  logic [CYC_W-1:0] last_i,
  output logic [CYC_W-1:0] last_o
);

  logic [CYC_W-1:0] last_q;
  logic [CYC_W-1:0] last_d;

  always_comb begin
    last_d = last_i;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)       last_q <= '0;
    else if (capture_i) last_q <= last_d;
  end

  assign last_o = last_q;

endmodule

// File: rtl/instr_sequencer.sv
module instr_sequencer
  import seq_pkg::*;
#(
  parameter int NPHASE    = SEQ_NPHASE,
  parameter int CYC_W     = SEQ_CYC_W,
  parameter int MODE_W    = SEQ_MODE_W,
  parameter int RST_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_i,
  output logic [NPHASE-1:0] phase_o,
  output logic [CYC_W-1:0]  cycle_o,
  output logic              fetch_o,
  output logic              opfetch_o,
  output logic              exec_o,
  output logic              done_o
);

  localparam int EXEC_PH = NPHASE - 2;
  localparam int LAST_PH = NPHASE - 1;

  logic             rst_q_n;
  logic             wrap;
  logic [CYC_W-1:0] last_live;
  logic [CYC_W-1:0] last_held;
  logic [CYC_W-1:0] last_eff;
  logic             first_cyc;
  logic             final_cyc;
  logic             capture;
  logic             done_int;

  seq_reset_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  seq_phase_ring #(.NPHASE(NPHASE)) u_ring (
    .clk     (clk),
    .rst_q_n (rst_q_n),
    .phase_o (phase_o),
    .wrap_o  (wrap)
  );

  seq_mode_hold #(.CYC_W(CYC_W)) u_hold (
    .clk       (clk),
    .rst_q_n   (rst_q_n),
    .capture_i (capture),
    .last_i    (last_live),
    .last_o    (last_held)
  );

  seq_cycle_ctr #(.CYC_W(CYC_W)) u_ctr (
    .clk     (clk),
    .rst_q_n (rst_q_n),
    .step_i  (wrap),
    .clear_i (done_int),
    .cycle_o (cycle_o)
  );

  always_comb begin
    last_live = CYC_W'(last_cycle(seq_mode_e'(mode_i[SEQ_MODE_W-1:0])));
    first_cyc = (cycle_o == '0);
    last_eff  = first_cyc ? last_live : last_held;
    final_cyc = (cycle_o == last_eff);
    capture   = wrap & first_cyc;
    done_int  = wrap & final_cyc;
  end

  // strobes are held low while the synchronised reset is active
  always_comb begin
    fetch_o   = rst_q_n & first_cyc  & phase_o[0];
    opfetch_o = rst_q_n & ~first_cyc & phase_o[0];
    exec_o    = rst_q_n & final_cyc  & phase_o[EXEC_PH];
    done_o    = rst_q_n & final_cyc  & phase_o[LAST_PH];
  end

endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
  parameter int NPHASE = 4,
  parameter int CYC_W  = 2
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic [NPHASE-1:0] phase_o,
  input logic [CYC_W-1:0]  cycle_o,
  input logic              fetch_o,
  input logic              opfetch_o,
  input logic              exec_o,
  input logic              done_o
);

  localparam int MAX_LAST = 2;

  assert_phase_onehot_R1: assert property (@(posedge clk) disable iff (!rst_q_n)
    $onehot(phase_o));

  assert_phase_rotate_R1: assert property (@(posedge clk) disable iff (!rst_q_n)
    1'b1 |=> phase_o == {$past(phase_o[NPHASE-2:0]), $past(phase_o[NPHASE-1])});

  assert_cycle_hold_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    !phase_o[NPHASE-1] |=> $stable(cycle_o));

  assert_cycle_max_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    cycle_o <= CYC_W'(MAX_LAST));

  assert_done_in_p3_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    done_o |-> phase_o[NPHASE-1]);

  assert_done_restart_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    done_o |=> (phase_o[0] && cycle_o == '0));

  assert_fetch_first_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    fetch_o |-> (cycle_o == '0 && phase_o[0]));

  assert_opfetch_later_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    opfetch_o |-> (cycle_o != '0 && phase_o[0]));

  assert_exec_then_done_R10: assert property (@(posedge clk) disable iff (!rst_q_n)
    exec_o |=> done_o);

endmodule

bind instr_sequencer seq_checker #(.NPHASE(NPHASE), .CYC_W(CYC_W)) u_chk (
  .clk       (clk),
  .rst_q_n   (rst_q_n),
  .phase_o   (phase_o),
  .cycle_o   (cycle_o),
  .fetch_o   (fetch_o),
  .opfetch_o (opfetch_o),
  .exec_o    (exec_o),
  .done_o    (done_o)
);

// File: tb/sim_instr_sequencer.sv
module sim_instr_sequencer;

  logic       clk;
  logic       rst_n;
  logic [1:0] mode_i;
  logic [3:0] phase_o;
  logic [1:0] cycle_o;
  logic       fetch_o, opfetch_o, exec_o, done_o;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  instr_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
    .phase_o(phase_o), .cycle_o(cycle_o),
    .fetch_o(fetch_o), .opfetch_o(opfetch_o),
    .exec_o(exec_o), .done_o(done_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // reference state
  int m_ph, m_cyc, m_last, rel_cnt, ins_idx, ins_done, neg_cnt, st_neg;
  logic [1:0] cur_mode;
  bit started, scrambled;

  function automatic int exp_last(logic [1:0] m);
    case (m)
      2'b00:   return 0;
      2'b01:   return 1;
      2'b10:   return 2;
      default: return 1;
    endcase
  endfunction

  function automatic logic [1:0] pick_mode(int n);
    logic [1:0] dir [8] = '{2'b00, 2'b01, 2'b10, 2'b11, 2'b00, 2'b00, 2'b10, 2'b11};
    if (n < 8) return dir[n];
    return 2'($urandom % 4);
  endfunction

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  always @(negedge rst_n) begin
    m_ph = 0; m_cyc = 0; m_last = 0; rel_cnt = 0;
    started = 0; scrambled = 0;
  end

  // reference advance on every rising edge
  always @(posedge clk) begin
    if (rst_n) begin
      if (rel_cnt < 2) rel_cnt++;
      else begin
        if (m_ph == 3) begin
          if (m_cyc == 0) m_last = exp_last(cur_mode);
          if (m_cyc == ((m_cyc == 0) ? exp_last(cur_mode) : m_last)) begin
            m_cyc = 0;
            ins_idx++;
            cur_mode = pick_mode(ins_idx);
            scrambled = 0;
          end else m_cyc++;
        end
        m_ph = (m_ph + 1) % 4;
      end
    end
  end

  // drive on falling edge, compare 1 ns later
  always @(negedge clk) begin
    bit act, fin;
    int got_len;
    act = (rst_n && rel_cnt == 2);
    if (act && m_cyc == 0 && m_ph >= 2) mode_i = cur_mode;
    else begin
      mode_i = 2'($urandom % 4);
      if (act && m_cyc != 0 && mode_i != cur_mode) scrambled = 1;
    end
    #1;
    neg_cnt++;
    fin = act && (m_cyc == ((m_cyc == 0) ? exp_last(cur_mode) : m_last));
    chk("R1 phase", phase_o, act ? (1 << m_ph) : 1);
    chk("R2 cycle", cycle_o, act ? m_cyc : 0);
    chk("R9 fetch", fetch_o, act && m_cyc == 0 && m_ph == 0);
    chk("R9 opfetch", opfetch_o, act && m_cyc != 0 && m_ph == 0);
    chk("R10 exec", exec_o, fin && m_ph == 2);
    chk("R8 done", done_o, fin && m_ph == 3);
    if (fetch_o) begin
      st_neg = neg_cnt;
      started = 1;
    end
    if (done_o && started) begin
      got_len = neg_cnt - st_neg + 1;
      case (cur_mode)
        2'b00:   chk("R3 inherent length", got_len, 4);
        2'b01:   chk("R4 immediate length", got_len, 8);
        2'b10:   chk("R5 direct length", got_len, 12);
        default: chk("R6 relative length", got_len, 8);
      endcase
      if (scrambled)
        chk("R7 late mode change ignored", got_len, 4 * (exp_last(cur_mode) + 1));
      ins_done++;
    end
  end

  initial begin
    void'($urandom(32'd20031));
    ins_idx = 0; ins_done = 0; neg_cnt = 0;
    cur_mode = pick_mode(0);
    mode_i = 2'b00;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R11 reset phase", phase_o, 1);
    chk("R11 reset strobes", {fetch_o, opfetch_o, exec_o, done_o}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1 chk("R11 held after 1 edge", phase_o, 1);
    @(negedge clk); #1 chk("R11 held after 2 edges", phase_o, 1);
    @(negedge clk); #1 chk("R11 advance on 3rd edge", phase_o, 2);
    wait (ins_done >= 600);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R11 async reset phase", phase_o, 1);
    chk("R11 async reset cycle", cycle_o, 0);
    chk("R11 async reset strobes", {fetch_o, opfetch_o, exec_o, done_o}, 0);
    ins_idx = 0;
    cur_mode = pick_mode(0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    wait (ins_done >= 1200);
    @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL R8 watchdog: got hang expected completion");
    finish_run();
  end

endmodule